// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words over a half-duplex synchronous serial link on which it acts as the clock master. A programmable divider produces the shift clock, and the receiver drives that clock onto its clock pin. The receiver samples the data line once per clock period. Each word is 8 bits, or 9 bits when the long-word control is set, and arrives least-significant bit first.

Reception runs in one of two modes. A one-shot request fetches a single word and then disarms itself. A continuous enable fetches words back to back for as long as it is held. Each finished word goes into a holding register and raises a receive-complete flag. An interrupt output mirrors the flag when interrupts are enabled. A read strobe acknowledges the word and clears the flag. A word that finishes while the previous one is still unread is not stored. It raises an overrun error and reception stops. Dropping the continuous enable clears the error.

Top module: `sync_master_rx`

## Requirements
- R1: A one-cycle pulse on `single_go` receives exactly one word. After that word the shift clock stays at its idle level, unless `cont_en` is high.
- R2: While `cont_en` is high, words are received back to back. Reception stops when `cont_en` goes low.
- R3: When `single_go` and `cont_en` are both set, continuous behaviour wins and more than one word is received.
- R4: Each bit is sampled on the clock edge where the shift clock returns from its active level to its idle level. The first bit sampled lands in bit 0 of `rx_data`.
- R5: With `nine_bit` = 1 a word is 9 bits long and the ninth bit appears on `rx_bit8`. With `nine_bit` = 0 a word is 8 bits long and `rx_bit8` reads 0.
- R6: `rx_done` rises when a word is stored and falls one cycle after a `rd_req` pulse. `rx_irq` is high exactly when `rx_done` and `irq_en` are both high.
- R7: The idle level of `sclk_out` equals `clk_inv`. The active level is its inverse.
- R8: The shift clock holds each level for D+1 cycles, so its period is 2(D+1). D is {`div_hi`,`div_lo`} when `wide_div` = 1, and `div_lo` alone when `wide_div` = 0.
- R9: A falling edge of `cont_en` clears `overrun` by the following cycle.
- R10: If a word completes while `rx_done` is still high and no read arrives in that cycle, `overrun` is set. The word is discarded, `rx_data` keeps the earlier word, and the clock stops until the error is cleared.
- R11: After reset, and whenever reception is not enabled, the clock sits at its idle level. After reset, `rx_done`, `overrun` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_go | input | 1 | Pulse: arm reception of one word |
| cont_en | input | 1 | Level: continuous reception; its falling edge clears overrun |
| nine_bit | input | 1 | 1 selects 9-bit words |
| clk_inv | input | 1 | Idle level of the shift clock |
| wide_div | input | 1 | 1 uses both divider bytes, 0 uses the low byte only |
| div_hi | input | HALF_W | Divider high byte |
| div_lo | input | HALF_W | Divider low byte |
| irq_en | input | 1 | Interrupt enable |
| rd_req | input | 1 | Read strobe: acknowledges the held word |
| sdata_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| rx_data | output | WORD_W | Received word, low bits |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_done | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun error |

## Verification
The hardest state to reach from the ports is overrun, followed by a clean restart. Reaching it needs a second complete word to arrive while the first is left unread, and this must happen under continuous mode. The scoreboard's automatic reader is switched off and two words are queued on the slave model. The bench then watches that the first word survives, that the clock freezes, and that lowering `cont_en` clears the error. A fresh one-shot word, checked by the scoreboard, then proves that reception resumes.

// File: rtl/sync_rx_pkg.sv
// Shared types for the synchronous master receiver.
// Assumes: nothing beyond the enum encoding below (idle = 0).
package sync_rx_pkg;
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } sclk_phase_e;
endpackage

// File: rtl/rx_baud_gen.sv
// Shift-clock generator. It counts system cycles up to the half-period
// limit and toggles the clock phase each time the limit is reached.
// Assumes: run low forces the counter and phase back to idle.
module rx_baud_gen
    import sync_rx_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wide,
    input  logic [HALF_W-1:0] div_hi,
    input  logic [HALF_W-1:0] div_lo,
    output sclk_phase_e       phase,
    output logic              fall_tick
);
    localparam int DIV_W = 2 * HALF_W;

    logic [DIV_W-1:0] half_lim;
    logic [DIV_W-1:0] cnt;
    logic             reached;

    // Pick the half-period limit from one or both divider bytes.
    always_comb begin
        half_lim = wide ? {div_hi, div_lo} : {{HALF_W{1'b0}}, div_lo};
        reached  = (cnt >= half_lim);
    end

    // Count cycles and toggle the phase at each limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= PH_IDLE;
        end else if (reached) begin
            cnt   <= '0;
            phase <= (phase == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the edge on which the clock returns to idle (the sample point).
    assign fall_tick = run && reached && (phase == PH_ACTIVE);
endmodule

// File: rtl/rx_shifter.sv
// Bit collector. On each sample tick it stores the data line at the next
// bit index, least-significant bit first. It flags the tick that completes
// a word and presents the full word, including that last bit, on the same cycle.
// Assumes: run low abandons any partial word.
module rx_shifter #(
    parameter int WORD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            nine,
    input  logic            fall_tick,
    input  logic            sdata,
    output logic [WORD_W:0] word_cap,
    output logic            word_done
);
    localparam int FULL_W = WORD_W + 1;
    localparam int IDX_W  = $clog2(FULL_W + 1);

    logic [FULL_W-1:0] sr;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last;

    // Index of the final bit for the selected word length.
    assign last      = nine ? IDX_W'(WORD_W) : IDX_W'(WORD_W - 1);
    assign word_done = fall_tick && (idx == last);

    // Advance the bit index per sample and wrap at the end of a word.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            idx <= '0;
        end else if (fall_tick) begin
            idx <= (idx == last) ? '0 : idx + 1'b1;
        end
    end

    // Store the sampled bit at its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (fall_tick) begin
            sr[idx] <= sdata;
        end
    end

    // Present the word with the bit being sampled this cycle merged in.
    for (genvar b = 0; b < FULL_W; b++) begin : g_cap
        assign word_cap[b] = (fall_tick && idx == IDX_W'(b)) ? sdata : sr[b];
    end
endmodule

// File: rtl/rx_holding.sv
// Control and holding stage. It keeps the one-shot arm, the stored word,
// the complete flag and the overrun error, and derives the run enable.
// Assumes: word_done is a single-cycle pulse from the shifter.
module rx_holding #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_go,
    input  logic              cont_en,
    input  logic              nine,
    input  logic              rd_req,
    input  logic              word_done,
    input  logic [WORD_W:0]   word_in,
    output logic              run,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_done,
    output logic              overrun
);
    logic single_arm;
    logic cont_q;
    logic load_ok;
    logic ovr_set;
    logic ovr_clr;

    // Decide whether to store, discard as overrun, or clear the error.
    always_comb begin
        load_ok = word_done && (!rx_done || rd_req);
        ovr_set = word_done && rx_done && !rd_req;
        ovr_clr = cont_q && !cont_en;
        run     = (cont_en || single_arm) && !overrun;
    end

    // Arm one-shot mode and disarm it at the end of any word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_arm <= 1'b0;
            cont_q     <= 1'b0;
        end else begin
            cont_q <= cont_en;
            if (word_done)      single_arm <= 1'b0;
            else if (single_go) single_arm <= 1'b1;
        end
    end

    // Keep the overrun error until continuous mode is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clr) overrun <= 1'b0;
        else if (ovr_set)      overrun <= 1'b1;
    end

    // Store completed words and manage the complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit8 <= 1'b0;
            rx_done <= 1'b0;
        end else if (load_ok) begin
            rx_data <= word_in[WORD_W-1:0];
            rx_bit8 <= nine & word_in[WORD_W];
            rx_done <= 1'b1;
        end else if (rd_req) begin
            rx_done <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_master_rx.sv
// Top of the synchronous master receiver. It joins the clock generator,
// the bit collector and the holding stage, and applies the clock polarity.
// Assumes: all control inputs are synchronous to clk.
module sync_master_rx
    import sync_rx_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_go,
    input  logic              cont_en,
    input  logic              nine_bit,
    input  logic              clk_inv,
    input  logic              wide_div,
    input  logic [HALF_W-1:0] div_hi,
    input  logic [HALF_W-1:0] div_lo,
    input  logic              irq_en,
    input  logic              rd_req,
    input  logic              sdata_in,
    output logic              sclk_out,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_done,
    output logic              rx_irq,
    output logic              overrun
);
    sclk_phase_e     phase;
    logic            fall_tick;
    logic            run;
    logic            word_done;
    logic [WORD_W:0] word_cap;

    rx_baud_gen #(.HALF_W(HALF_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .wide(wide_div),
        .div_hi(div_hi), .div_lo(div_lo),
        .phase(phase), .fall_tick(fall_tick)
    );

    rx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .nine(nine_bit),
        .fall_tick(fall_tick), .sdata(sdata_in),
        .word_cap(word_cap), .word_done(word_done)
    );

    rx_holding #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .single_go(single_go), .cont_en(cont_en),
        .nine(nine_bit), .rd_req(rd_req), .word_done(word_done),
        .word_in(word_cap), .run(run), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .rx_done(rx_done), .overrun(overrun)
    );

    // Drive the pin with the selected polarity and gate the interrupt.
    assign sclk_out = (phase == PH_ACTIVE) ^ clk_inv;
    assign rx_irq   = rx_done & irq_en;
endmodule

// File: rtl/sync_master_rx_chk.sv
// Property checker for sync_master_rx, attached with bind below.
module sync_master_rx_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cont_en,
    input logic              clk_inv,
    input logic              rd_req,
    input logic              sclk_out,
    input logic              run,
    input logic              word_done,
    input logic              rx_done,
    input logic              overrun,
    input logic [WORD_W-1:0] rx_data
);
    // R1
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && !cont_en |=> !run || cont_en);
    // R4
    sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> sclk_out != clk_inv);
    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !word_done |=> !rx_done);
    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cont_en) |=> !overrun);
    // R10
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rx_data));
    // R10
    overrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> sclk_out == clk_inv);
    // R11
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk_out == clk_inv);
endmodule

bind sync_master_rx sync_master_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .clk_inv(clk_inv),
    .rd_req(rd_req), .sclk_out(sclk_out), .run(run), .word_done(word_done),
    .rx_done(rx_done), .overrun(overrun), .rx_data(rx_data)
);

// File: tb/sync_master_rx_tb_top.sv
// Scoreboard bench: the driver queues slave words and expected results;
// the monitor pops and compares every stored word, then reads it.
module sync_master_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       single_go = 1'b0, cont_en = 1'b0, nine_bit = 1'b0;
    logic       clk_inv = 1'b0, wide_div = 1'b0, irq_en = 1'b0;
    logic [7:0] div_hi = 8'd0, div_lo = 8'd2;
    logic       rd_mon = 1'b0, rd_man = 1'b0, sdata_in = 1'b0;
    logic       rd_req;
    logic       sclk_out, rx_bit8, rx_done, rx_irq, overrun;
    logic [7:0] rx_data;

    assign rd_req = rd_mon | rd_man;

    sync_master_rx dut_i (
        .clk(clk), .rst_n(rst_n), .single_go(single_go), .cont_en(cont_en),
        .nine_bit(nine_bit), .clk_inv(clk_inv), .wide_div(wide_div),
        .div_hi(div_hi), .div_lo(div_lo), .irq_en(irq_en), .rd_req(rd_req),
        .sdata_in(sdata_in), .sclk_out(sclk_out), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .rx_done(rx_done), .rx_irq(rx_irq), .overrun(overrun)
    );

    always #5 clk = ~clk;

    int total = 0, failed = 0, words_seen = 0;
    int edge_cnt = 0, last_edge = 0, prev_edge = 0, cyc = 0, sbit = 0;
    bit auto_read = 1'b1, finished = 1'b0, prev_act = 1'b0;
    logic [8:0] slave_q[$];
    logic [8:0] exp_q[$];

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    // Driver: queue a word on the slave and its expected result.
    task automatic send(logic [8:0] w);
        slave_q.push_back(w);
        exp_q.push_back(nine_bit ? w : {1'b0, w[7:0]});
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0 || rx_done) @(negedge clk);
    endtask

    task automatic pulse_read();
        rd_man = 1'b1;
        @(negedge clk);
        rd_man = 1'b0;
    endtask

    task automatic flush();
        cont_en = 1'b0;
        repeat (3) @(negedge clk);
        if (rx_done) pulse_read();
        repeat (2) @(negedge clk);
    endtask

    // Slave model: present the next bit on each idle-to-active clock edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if ((sclk_out ^ clk_inv) && !prev_act) begin
                prev_edge = last_edge;
                last_edge = cyc;
                edge_cnt++;
                if (slave_q.size() > 0) begin
                    sdata_in = slave_q[0][sbit];
                    sbit++;
                    if (sbit == (nine_bit ? 9 : 8)) begin
                        void'(slave_q.pop_front());
                        sbit = 0;
                    end
                end else begin
                    sdata_in = 1'b0;
                end
            end
            prev_act = sclk_out ^ clk_inv;
        end
    end

    // Monitor: compare each stored word with the scoreboard, then read it.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_mon) begin
                rd_mon = 1'b0;
            end else if (auto_read && rx_done) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected word", 1, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk("R4 rx_data", int'(rx_data), int'(e[7:0]));
                    chk("R5 rx_bit8", int'(rx_bit8), int'(e[8]));
                end
                words_seen++;
                rd_mon = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int e0, w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rx_done", int'(rx_done), 0);
        chk("R11 overrun", int'(overrun), 0);
        chk("R11 sclk_out", int'(sclk_out), 0);
        chk("R11 rx_irq", int'(rx_irq), 0);

        // R1 one-shot word in 8-bit mode (R5: bit8 reads 0)
        send(9'h1A5);
        single_go = 1'b1; @(negedge clk); single_go = 1'b0;
        wait_drained();
        e0 = edge_cnt;
        repeat (100) @(negedge clk);
        chk("R1 no clock after one word", edge_cnt, e0);
        chk("R11 idle level", int'(sclk_out), 0);

        // R2 continuous 9-bit words (R5)
        nine_bit = 1'b1;
        w0 = words_seen;
        send(9'h13C); send(9'h0C3); send(9'h1FF);
        cont_en = 1'b1;
        wait_drained();
        cont_en = 1'b0;
        chk("R2 words received", words_seen - w0, 3);
        repeat (5) @(negedge clk);
        e0 = edge_cnt;
        repeat (40) @(negedge clk);
        chk("R2 stops after clear", edge_cnt, e0);
        nine_bit = 1'b0;
        sbit = 0;
        slave_q.delete();

        // R3 both enables: continuous wins
        w0 = words_seen;
        send(9'h011); send(9'h022);
        single_go = 1'b1; cont_en = 1'b1;
        @(negedge clk); single_go = 1'b0;
        wait_drained();
        cont_en = 1'b0;
        chk("R3 two words", words_seen - w0, 2);
        repeat (5) @(negedge clk);
        sbit = 0;
        slave_q.delete();

        // R7 inverted clock polarity
        clk_inv = 1'b1;
        @(negedge clk);
        chk("R7 idle high", int'(sclk_out), 1);
        send(9'h05A);
        single_go = 1'b1; @(negedge clk); single_go = 1'b0;
        wait_drained();
        repeat (5) @(negedge clk);
        chk("R7 idle high after word", int'(sclk_out), 1);
        clk_inv = 1'b0;
        @(negedge clk);

        // R6 interrupt and read handshake
        auto_read = 1'b0;
        irq_en = 1'b1;
        slave_q.push_back(9'h077);
        single_go = 1'b1; @(negedge clk); single_go = 1'b0;
        while (!rx_done) @(negedge clk);
        chk("R6 rx_irq set", int'(rx_irq), 1);
        chk("R6 rx_data", int'(rx_data), 8'h77);
        irq_en = 1'b0; #1;
        chk("R6 rx_irq masked", int'(rx_irq), 0);
        irq_en = 1'b1;
        pulse_read();
        chk("R6 rx_done cleared", int'(rx_done), 0);
        chk("R6 rx_irq cleared", int'(rx_irq), 0);
        irq_en = 1'b0;

        // R8 divider: 16-bit and 8-bit selection
        wide_div = 1'b1; div_hi = 8'h01; div_lo = 8'h00;
        e0 = edge_cnt;
        cont_en = 1'b1;
        while (edge_cnt < e0 + 2) @(negedge clk);
        chk("R8 wide period", last_edge - prev_edge, 514);
        flush();
        wide_div = 1'b0; div_lo = 8'h03;
        e0 = edge_cnt;
        cont_en = 1'b1;
        while (edge_cnt < e0 + 2) @(negedge clk);
        chk("R8 narrow period ignores high byte", last_edge - prev_edge, 8);
        flush();
        sbit = 0;
        div_hi = 8'h00; div_lo = 8'h01;

        // R10 overrun, then R9 clear by dropping cont_en
        slave_q.push_back(9'h0C8); slave_q.push_back(9'h03D);
        cont_en = 1'b1;
        while (!overrun) @(negedge clk);
        chk("R10 first word kept", int'(rx_data), 8'hC8);
        chk("R10 rx_done held", int'(rx_done), 1);
        e0 = edge_cnt;
        repeat (50) @(negedge clk);
        chk("R10 clock frozen", edge_cnt, e0);
        cont_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 overrun cleared", int'(overrun), 0);
        pulse_read();
        chk("R9 flag read", int'(rx_done), 0);
        sbit = 0;
        slave_q.delete();
        auto_read = 1'b1;
        send(9'h096);
        single_go = 1'b1; @(negedge clk); single_go = 1'b0;
        wait_drained();
        chk("R9 reception resumes", int'(overrun), 0);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule